// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit

This block turns virtual addresses into physical addresses for a processor core. It keeps two direct-mapped translation tables, one for instruction fetches and one for data accesses. Each entry pairs a tag word with a frame word. A lookup takes a virtual address, an access kind and the privilege level of the requester. One cycle later it reports the physical address and the rights granted, or a fault code. When a lookup faults, the block captures the failing virtual address in a holding register.

A single write port fills the tables. A refill handler outside this block owns the replacement policy. A bypass input turns translation off: every address then passes through unchanged with full rights.

Bit layout of the frame word: bits [31:13] hold the physical page frame. Bits [5:0] are rights flags: [0] user read, [1] user write, [2] user execute, [3] privileged read, [4] privileged write, [5] privileged execute. In the tag word, bits [31:13] hold the full virtual page number and bit 0 is the valid flag.

Top module: `tlbx_unit`

## Requirements
- R1: After reset every tag word is zero, so every entry is invalid. `rsp_valid_o` is 0 and `fault_addr_o` is 0, and the first lookup of any address reports a miss.
- R2: `rsp_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. Response outputs change only on such cycles.
- R3: The entry index is the low 6 bits of the virtual page number (vaddr[18:13]). A lookup hits only when tag bits [31:13] equal the full virtual page number vaddr[31:13]; otherwise it reports a miss.
- R4: An entry whose tag matches but whose valid bit (bit 0) is clear reports a miss.
- R5: With `req_super_i` high, rights come from the privileged flags of the frame word; with it low, from the user flags.
- R6: A fetch without execute right, a read without read right, or a write without write right reports a page fault rather than a miss.
- R7: On a hit the physical address is {frame[31:13], vaddr[12:0]}. `rsp_rights_o` is {x,w,r}: a fetch reports only x, and a data access reports only w and r.
- R8: With `bypass_i` high the physical address equals the virtual address, the rights are 3'b111 and there is no fault, whatever the table contents.
- R9: Fault codes: 0 none, 1 instruction miss, 2 data miss, 3 instruction page fault, 4 data page fault. A faulting response drives the physical address and rights to zero.
- R10: `fault_addr_o` takes the virtual address of every faulting lookup and holds its value otherwise.
- R11: Access kind 0 is fetch, 1 is read and 2 is write; the value 3 acts as a read. A fetch uses only the instruction table and other kinds use only the data table. `wr_tbl_i` picks the table (0 instruction, 1 data) and `wr_word_i` picks the word (0 tag, 1 frame). A write is seen by lookups issued from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_i | input | 1 | Translation off: identity mapping with full rights |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| req_super_i | input | 1 | Requester is privileged |
| wr_en_i | input | 1 | Table write strobe |
| wr_tbl_i | input | 1 | 0 instruction table, 1 data table |
| wr_idx_i | input | 6 | Entry index to write |
| wr_word_i | input | 1 | 0 tag word, 1 frame word |
| wr_val_i | input | 32 | Value written |
| rsp_valid_o | output | 1 | Response valid |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_rights_o | output | 3 | Granted rights {x,w,r} |
| rsp_fault_o | output | 3 | Fault code |
| fault_addr_o | output | 32 | Last faulting virtual address |

## Verification
The assertions assume that reset is high from the first clock edge and that `req_kind_i` and `bypass_i` are known on every cycle with `req_valid_i` high. They also assume that the refill side never writes an entry in the same cycle as a lookup of that entry, because such a lookup would see the old contents. The stimulus keeps table writes and lookups in separate cycles. It draws access kinds only from the three defined values. It holds reset for several cycles before the first request.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_IMISS = 3'd1,
        FLT_DMISS = 3'd2,
        FLT_IPERM = 3'd3,
        FLT_DPERM = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        LK_HIT     = 2'd0,
        LK_NOMATCH = 2'd1,
        LK_INVALID = 2'd2
    } look_e;

    // rights flag positions in the frame word
    localparam int RB_UR = 0;
    localparam int RB_UW = 1;
    localparam int RB_UX = 2;
    localparam int RB_SR = 3;
    localparam int RB_SW = 4;
    localparam int RB_SX = 5;
    localparam int RB_W  = 6;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    function automatic rights_t pick_rights(input logic [RB_W-1:0] flags,
                                            input logic sup,
                                            input logic fetch);
        rights_t g;
        g = '0;
        if (fetch) begin
            g.x = sup ? flags[RB_SX] : flags[RB_UX];
        end else begin
            g.r = sup ? flags[RB_SR] : flags[RB_UR];
            g.w = sup ? flags[RB_SW] : flags[RB_UW];
        end
        return g;
    endfunction

    function automatic logic right_needed(input rights_t g, input acc_e kind);
        logic ok;
        case (kind)
            ACC_FETCH: ok = g.x;
            ACC_WRITE: ok = g.w;
            default:   ok = g.r;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlbx_way.sv
module tlbx_way
    import tlbx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_word,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic [ADDR_W-1:0]   wr_val,
    input  logic [ADDR_W-1:0]   lk_vaddr,
    output look_e               lk_status,
    output logic [ADDR_W-1:0]   lk_xlat
);
    localparam int ENTRIES = 1 << IDX_BITS;
    localparam int VPN_W   = ADDR_W - PAGE_BITS;

    logic [ADDR_W-1:0] tag_q  [ENTRIES];
    logic [ADDR_W-1:0] xlat_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                xlat_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (wr_word) xlat_q[wr_idx] <= wr_val;
            else         tag_q[wr_idx]  <= wr_val;
        end
    end

    logic [VPN_W-1:0]    vpn;
    logic [IDX_BITS-1:0] idx;
    logic [ADDR_W-1:0]   ent;
    logic                unused_way_bits;

    always_comb begin
        vpn     = lk_vaddr[ADDR_W-1:PAGE_BITS];
        idx     = vpn[IDX_BITS-1:0];
        ent     = tag_q[idx];
        lk_xlat = xlat_q[idx];
        if (ent[ADDR_W-1:PAGE_BITS] != vpn) lk_status = LK_NOMATCH;
        else if (!ent[0])                   lk_status = LK_INVALID;
        else                                lk_status = LK_HIT;
    end

    assign unused_way_bits = ^{ent[PAGE_BITS-1:1], lk_vaddr[PAGE_BITS-1:0]};

endmodule

// File: rtl/tlbx_grant.sv
module tlbx_grant
    import tlbx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13
) (
    input  look_e             status,
    input  logic [ADDR_W-1:0] xlat,
    input  logic [ADDR_W-1:0] vaddr,
    input  acc_e              kind,
    input  logic              sup,
    input  logic              bypass,
    output fault_e            fault,
    output logic [ADDR_W-1:0] paddr,
    output rights_t           rights
);
    logic    fetch;
    rights_t granted;
    logic    unused_grant_bits;

    always_comb begin
        fetch   = (kind == ACC_FETCH);
        granted = pick_rights(xlat[RB_W-1:0], sup, fetch);
        fault   = FLT_NONE;
        paddr   = '0;
        rights  = '0;
        if (bypass) begin
            paddr  = vaddr;
            rights = '{x: 1'b1, w: 1'b1, r: 1'b1};
        end else if (status != LK_HIT) begin
            fault = fetch ? FLT_IMISS : FLT_DMISS;
        end else if (!right_needed(granted, kind)) begin
            fault = fetch ? FLT_IPERM : FLT_DPERM;
        end else begin
            paddr  = {xlat[ADDR_W-1:PAGE_BITS], vaddr[PAGE_BITS-1:0]};
            rights = granted;
        end
    end

    assign unused_grant_bits = ^xlat[PAGE_BITS-1:RB_W];

endmodule

// File: rtl/tlbx_unit.sv
module tlbx_unit
    import tlbx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bypass_i,
    input  logic                req_valid_i,
    input  logic [ADDR_W-1:0]   req_vaddr_i,
    input  logic [1:0]          req_kind_i,
    input  logic                req_super_i,
    input  logic                wr_en_i,
    input  logic                wr_tbl_i,
    input  logic [IDX_BITS-1:0] wr_idx_i,
    input  logic                wr_word_i,
    input  logic [ADDR_W-1:0]   wr_val_i,
    output logic                rsp_valid_o,
    output logic [ADDR_W-1:0]   rsp_paddr_o,
    output logic [2:0]          rsp_rights_o,
    output logic [2:0]          rsp_fault_o,
    output logic [ADDR_W-1:0]   fault_addr_o
);
    localparam int NWAYS = 2;  // 0 instruction, 1 data

    acc_e              kind;
    look_e             way_status [NWAYS];
    logic [ADDR_W-1:0] way_xlat   [NWAYS];
    look_e             sel_status;
    logic [ADDR_W-1:0] sel_xlat;
    fault_e            nxt_fault;
    logic [ADDR_W-1:0] nxt_paddr;
    rights_t           nxt_rights;

    assign kind = acc_e'(req_kind_i);

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        tlbx_way #(
            .ADDR_W   (ADDR_W),
            .PAGE_BITS(PAGE_BITS),
            .IDX_BITS (IDX_BITS)
        ) way_i (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en_i && (wr_tbl_i == w[0])),
            .wr_word  (wr_word_i),
            .wr_idx   (wr_idx_i),
            .wr_val   (wr_val_i),
            .lk_vaddr (req_vaddr_i),
            .lk_status(way_status[w]),
            .lk_xlat  (way_xlat[w])
        );
    end

    always_comb begin
        if (kind == ACC_FETCH) begin
            sel_status = way_status[0];
            sel_xlat   = way_xlat[0];
        end else begin
            sel_status = way_status[1];
            sel_xlat   = way_xlat[1];
        end
    end

    tlbx_grant #(
        .ADDR_W   (ADDR_W),
        .PAGE_BITS(PAGE_BITS)
    ) grant_i (
        .status(sel_status),
        .xlat  (sel_xlat),
        .vaddr (req_vaddr_i),
        .kind  (kind),
        .sup   (req_super_i),
        .bypass(bypass_i),
        .fault (nxt_fault),
        .paddr (nxt_paddr),
        .rights(nxt_rights)
    );

    fault_e            fault_q;
    logic [ADDR_W-1:0] paddr_q;
    rights_t           rights_q;
    logic              valid_q;
    logic [ADDR_W-1:0] ea_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            fault_q  <= FLT_NONE;
            paddr_q  <= '0;
            rights_q <= '0;
            ea_q     <= '0;
        end else begin
            valid_q <= req_valid_i;
            if (req_valid_i) begin
                fault_q  <= nxt_fault;
                paddr_q  <= nxt_paddr;
                rights_q <= nxt_rights;
                if (nxt_fault != FLT_NONE) ea_q <= req_vaddr_i;
            end
        end
    end

    assign rsp_valid_o  = valid_q;
    assign rsp_paddr_o  = paddr_q;
    assign rsp_rights_o = rights_q;
    assign rsp_fault_o  = fault_q;
    assign fault_addr_o = ea_q;

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o);
    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)));
    assert_bypass_identity_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && bypass_i) |=>
        (rsp_paddr_o == $past(req_vaddr_i) && rsp_rights_o == 3'b111 && rsp_fault_o == 3'd0));
    assert_offset_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !bypass_i) |=>
        (rsp_fault_o != 3'd0 ||
         rsp_paddr_o[PAGE_BITS-1:0] == $past(req_vaddr_i[PAGE_BITS-1:0])));
    assert_fetch_no_data_rights_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !bypass_i && req_kind_i == 2'd0) |=> (rsp_rights_o[1:0] == 2'b00));
    assert_fault_clears_grant_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_fault_o != 3'd0) |-> (rsp_rights_o == 3'b000 && rsp_paddr_o == '0));
    assert_fault_code_range_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_fault_o <= 3'd4);
    assert_ea_capture_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_fault_o != 3'd0) |-> (fault_addr_o == $past(req_vaddr_i)));
    assert_ea_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid_o && rsp_fault_o != 3'd0) |-> $stable(fault_addr_o));

endmodule

// File: tb/tlbx_unit_tb.sv
module tlbx_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bypass_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_vaddr_i = '0;
    logic [1:0]  req_kind_i = '0;
    logic        req_super_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        wr_tbl_i = 1'b0;
    logic [5:0]  wr_idx_i = '0;
    logic        wr_word_i = 1'b0;
    logic [31:0] wr_val_i = '0;
    logic        rsp_valid_o;
    logic [31:0] rsp_paddr_o;
    logic [2:0]  rsp_rights_o;
    logic [2:0]  rsp_fault_o;
    logic [31:0] fault_addr_o;

    always #5 clk = ~clk;

    tlbx_unit dut_i (
        .clk(clk), .rst(rst), .bypass_i(bypass_i), .req_valid_i(req_valid_i),
        .req_vaddr_i(req_vaddr_i), .req_kind_i(req_kind_i), .req_super_i(req_super_i),
        .wr_en_i(wr_en_i), .wr_tbl_i(wr_tbl_i), .wr_idx_i(wr_idx_i), .wr_word_i(wr_word_i),
        .wr_val_i(wr_val_i), .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o),
        .rsp_rights_o(rsp_rights_o), .rsp_fault_o(rsp_fault_o), .fault_addr_o(fault_addr_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] m_tag  [2][64];
    logic [31:0] m_xlat [2][64];
    logic [31:0] m_ea = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_entry(input bit tbl, input int idx, input bit word, input logic [31:0] v);
        @(negedge clk);
        wr_en_i = 1'b1; wr_tbl_i = tbl; wr_idx_i = idx[5:0]; wr_word_i = word; wr_val_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (word) m_xlat[tbl][idx] = v;
        else      m_tag[tbl][idx]  = v;
    endtask

    // expected {fault, rights, paddr} from the requirements
    function automatic logic [37:0] expect_rsp(input logic [31:0] va, input logic [1:0] kind,
                                               input bit sup, input bit byp);
        bit          tbl;
        int          idx;
        logic [31:0] t, f;
        bit          x, r, w, ok;
        logic [2:0]  flt, rts;
        logic [31:0] pa;
        if (byp) return {3'd0, 3'b111, va};
        tbl = (kind != 2'd0);
        idx = int'(va[18:13]);
        t = m_tag[tbl][idx];
        f = m_xlat[tbl][idx];
        if (t[31:13] != va[31:13] || !t[0]) return {(tbl ? 3'd2 : 3'd1), 3'b000, 32'h0};
        x = sup ? f[5] : f[2];
        r = sup ? f[3] : f[0];
        w = sup ? f[4] : f[1];
        if (!tbl) begin ok = x; rts = {x, 2'b00}; end
        else begin ok = (kind == 2'd2) ? w : r; rts = {1'b0, w, r}; end
        if (!ok) return {(tbl ? 3'd4 : 3'd3), 3'b000, 32'h0};
        flt = 3'd0;
        pa = {f[31:13], va[12:0]};
        return {flt, rts, pa};
    endfunction

    task automatic lookup(input string req, input logic [31:0] va, input logic [1:0] kind,
                          input bit sup, input bit byp);
        logic [37:0] e;
        e = expect_rsp(va, kind, sup, byp);
        @(negedge clk);
        req_valid_i = 1'b1; req_vaddr_i = va; req_kind_i = kind;
        req_super_i = sup; bypass_i = byp;
        @(negedge clk);
        req_valid_i = 1'b0; bypass_i = 1'b0;
        if (e[37:35] != 3'd0) m_ea = va;
        check({req, " valid"},  {31'h0, rsp_valid_o}, 32'h1);
        check({req, " fault"},  {29'h0, rsp_fault_o}, {29'h0, e[37:35]});
        check({req, " rights"}, {29'h0, rsp_rights_o}, {29'h0, e[34:32]});
        check({req, " paddr"},  rsp_paddr_o, e[31:0]);
        check({req, " R10 ea"}, fault_addr_o, m_ea);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_7171));
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 64; i++) begin m_tag[t][i] = '0; m_xlat[t][i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rsp_valid", {31'h0, rsp_valid_o}, 32'h0);
        check("R1 fault_addr", fault_addr_o, 32'h0);
        lookup("R1 fetch at zero", 32'h0000_0000, 2'd0, 1'b1, 1'b0);
        lookup("R1 data read", 32'h4000_2468, 2'd1, 1'b0, 1'b0);
        // R2 idle cycle drops valid and holds outputs
        @(negedge clk);
        check("R2 idle valid", {31'h0, rsp_valid_o}, 32'h0);
        check("R2 idle fault hold", {29'h0, rsp_fault_o}, 32'h2);
        // data entry idx 5, full rights
        write_entry(1, 5, 0, {19'h1_2345 & 19'h7_FFC0 | 19'd5, 12'h0, 1'b1});
        write_entry(1, 5, 1, {19'h0_ABCD, 7'h0, 6'b111111});
        lookup("R7 data hit", {19'h1_2345 & 19'h7_FFC0 | 19'd5, 13'h1ABC}, 2'd1, 1'b0, 1'b0);
        lookup("R10 ea held after hit", {19'h1_2345 & 19'h7_FFC0 | 19'd5, 13'h0004}, 2'd2, 1'b1, 1'b0);
        // R3 same index, other upper tag
        lookup("R3 alias miss", {19'h0_0045, 13'h0010}, 2'd1, 1'b0, 1'b0);
        // R11 fetch of the same address uses instruction table
        lookup("R11 table split", {19'h1_2345 & 19'h7_FFC0 | 19'd5, 13'h0}, 2'd0, 1'b1, 1'b0);
        // R4 tag matches, valid clear
        write_entry(1, 9, 0, {19'h0_0209, 13'h0});
        lookup("R4 invalid entry", {19'h0_0209, 13'h0100}, 2'd1, 1'b1, 1'b0);
        // R5/R6 privileged only rights
        write_entry(0, 3, 0, {19'h0_7F03, 13'h1});
        write_entry(0, 3, 1, {19'h0_1111, 7'h0, 6'b111000});
        lookup("R5 priv fetch", {19'h0_7F03, 13'h0FFF}, 2'd0, 1'b1, 1'b0);
        lookup("R6 user fetch perm", {19'h0_7F03, 13'h0FFF}, 2'd0, 1'b0, 1'b0);
        write_entry(1, 10, 0, {19'h0_300A, 13'h1});
        write_entry(1, 10, 1, {19'h0_2222, 7'h0, 6'b000001});
        lookup("R6 user write perm", {19'h0_300A, 13'h0020}, 2'd2, 1'b0, 1'b0);
        lookup("R5 user read ok", {19'h0_300A, 13'h0020}, 2'd1, 1'b0, 1'b0);
        lookup("R6 priv read perm", {19'h0_300A, 13'h0020}, 2'd1, 1'b1, 1'b0);
        // R8 bypass ignores tables
        lookup("R8 bypass", 32'hDEAD_BEEF, 2'd2, 1'b0, 1'b1);
        lookup("R8 bypass fetch", {19'h0_300A, 13'h0020}, 2'd0, 1'b0, 1'b1);
        // random phase: R3 R5 R6 R7 R9 R11
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 64; i++) begin
                logic [18:0] vpn;
                vpn = {$urandom_range(0, 8191)[12:0], i[5:0]};
                write_entry(t[0], i, 0, {vpn, $urandom_range(0, 4095)[11:0], ($urandom_range(0, 99) < 85)});
                write_entry(t[0], i, 1, $urandom);
            end
        for (int n = 0; n < 3000; n++) begin
            logic [1:0]  k;
            logic [31:0] va;
            int          idx;
            k = 2'($urandom_range(0, 2));
            idx = $urandom_range(0, 63);
            if ($urandom_range(0, 9) < 7)
                va = {m_tag[k != 2'd0][idx][31:13], $urandom_range(0, 8191)[12:0]};
            else
                va = $urandom;
            if (n % 200 == 17)
                write_entry($urandom_range(0, 1), idx, $urandom_range(0, 1), $urandom | 32'h1);
            lookup("R3/R5/R6/R7/R9/R11 random", va, k, $urandom_range(0, 1), ($urandom_range(0, 19) == 0));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule